// File: doc/BRIEF.md
# Pixel-to-Channel-Vector Layout Transform

This block sits between a video source and the input buffer of a neural-network accelerator. Each incoming pixel carries red, green and blue components. The block turns each component into a separate input channel and converts it to half-precision floating point. It then places the three channels at the bottom of a wide channel vector and fills the rest of the vector with zero. The number of lanes in the vector (`CVEC`) is a parameter and is chosen to match the accelerator's channel depth, typically 8, 16 or 32.

Each vector holds exactly one pixel, with no folding. Both sides use a valid/ready handshake. The start-of-frame and end-of-line markers travel with their pixel through a fixed two-register pipeline. A stall on the output propagates back to the input without dropping or repeating any pixel.

Top module: `pxv_layout_xform`

## Requirements
- R1: While `rst` is high, and afterwards until a pixel has been accepted, `out_valid` is low. A synchronous active-high reset empties both pipeline registers.
- R2: Lane k occupies `out_vec[16*k+15:16*k]`. Red goes to lane 0, green to lane 1 and blue to lane 2.
- R3: Each component is an unsigned integer that is converted exactly to FP16. A value of 0 gives 16'h0000. A nonzero value v gives sign 0, exponent field 15+floor(log2 v), and the bits below the leading one left-aligned in the 10-bit fraction. For example, 1 gives 16'h3C00, 128 gives 16'h5800 and 255 gives 16'h5BF8.
- R4: Every lane from 3 to `CVEC`-1 is 16'h0000 whenever `out_valid` is high.
- R5: Each accepted pixel produces exactly one output vector, in acceptance order. No pixel is lost or duplicated under any pattern of `out_ready`.
- R6: With the output not stalled, a pixel accepted at rising edge k is captured into the first register at edge k and presented on the output after edge k+1. It is not presented after edge k alone.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_vec`, `out_sof` and `out_eol` hold their values.
- R8: When both pipeline registers are full and `out_ready` is low, `in_ready` is low. With the output stalled from empty, exactly two pixels are accepted.
- R9: `out_sof` and `out_eol` equal the `in_sof` and `in_eol` that were presented with the pixel now on `out_vec`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input pixel present |
| in_ready | output | 1 | Block can take a pixel this cycle |
| in_red | input | COMP_W | Red component, unsigned |
| in_green | input | COMP_W | Green component, unsigned |
| in_blue | input | COMP_W | Blue component, unsigned |
| in_sof | input | 1 | Pixel is first of a frame |
| in_eol | input | 1 | Pixel is last of a line |
| out_valid | output | 1 | Output vector present |
| out_ready | input | 1 | Consumer takes the vector this cycle |
| out_vec | output | 16*CVEC | Channel vector of FP16 lanes, lane 0 lowest |
| out_sof | output | 1 | Start-of-frame marker of the output pixel |
| out_eol | output | 1 | End-of-line marker of the output pixel |

## Verification
The bench sweeps every component value from 0 to 255 on red, with mirrored and scrambled values on green and blue. A wrong exponent bias, an off-by-one in the leading-one search, or a fraction that is not left-aligned then shows up as a lane mismatch. A sweep that skipped zero would miss the special all-zero encoding. The bench fills the pipe under a held stall and checks that exactly two pixels go in and that the output freezes. A ready path that ignores the second register would accept a third pixel and overwrite one. A register that reloads while stalled would change the held vector. A one-register pipeline is caught by checking that the output is still idle after the first edge. Irregular ready patterns during the sweep expose lost or repeated pixels and flags that drift away from their pixel.

// File: rtl/pxv_pkg.sv
package pxv_pkg;
   localparam int HALF_W    = 16;
   localparam int EXP_W     = 5;
   localparam int FRAC_W    = 10;
   localparam int EXP_BIAS  = 15;
   localparam int NUM_COLOR = 3;
   localparam int LANE_RED  = 0;
   localparam int LANE_GRN  = 1;
   localparam int LANE_BLU  = 2;

   typedef logic [HALF_W-1:0] half_t;
endpackage

// File: rtl/pxv_int_to_half.sv
module pxv_int_to_half
   import pxv_pkg::*;
#(
   parameter int COMP_W = 8
) (
   input  logic [COMP_W-1:0] value,
   output half_t             half
);
   localparam int SIG_W = FRAC_W + 1;
   localparam int POS_W = $clog2(SIG_W + 1);

   logic [POS_W-1:0] lead_pos;
   logic             nonzero;
   logic [SIG_W-1:0] widened;
   logic [SIG_W-1:0] aligned;
   logic [EXP_W-1:0] exp_field;

   // Leading-one search; the highest set bit wins.
   always_comb begin
      lead_pos = '0;
      nonzero  = 1'b0;
      for (int b = 0; b < COMP_W; b++) begin
         if (value[b]) begin
            lead_pos = POS_W'(b);
            nonzero  = 1'b1;
         end
      end
   end

   assign widened   = SIG_W'(value);
   assign aligned   = widened << (POS_W'(FRAC_W) - lead_pos);
   assign exp_field = EXP_W'(EXP_BIAS) + EXP_W'(lead_pos);
   assign half      = nonzero ? {1'b0, exp_field, aligned[FRAC_W-1:0]} : '0;
endmodule

// File: rtl/pxv_pipe_reg.sv
module pxv_pipe_reg #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         up_valid,
   output logic         up_ready,
   input  logic [W-1:0] up_data,
   output logic         dn_valid,
   input  logic         dn_ready,
   output logic [W-1:0] dn_data
);
   assign up_ready = !dn_valid || dn_ready;

   always_ff @(posedge clk) begin
      if (rst) begin
         dn_valid <= 1'b0;
      end else if (up_ready) begin
         dn_valid <= up_valid;
      end
   end

   always_ff @(posedge clk) begin
      if (up_valid && up_ready) begin
         dn_data <= up_data;
      end
   end
endmodule

// File: rtl/pxv_lane_pack.sv
module pxv_lane_pack
   import pxv_pkg::*;
#(
   parameter int CVEC   = 16,
   parameter int COMP_W = 8
) (
   input  logic [NUM_COLOR*COMP_W-1:0] comps,
   output logic [CVEC*HALF_W-1:0]      vec
);
   for (genvar lane = 0; lane < CVEC; lane++) begin : g_lane
      if (lane < NUM_COLOR) begin : g_color
         pxv_int_to_half #(.COMP_W(COMP_W)) u_conv (
            .value (comps[lane*COMP_W +: COMP_W]),
            .half  (vec[lane*HALF_W +: HALF_W])
         );
      end else begin : g_pad
         assign vec[lane*HALF_W +: HALF_W] = '0;
      end
   end
endmodule

// File: rtl/pxv_layout_xform.sv
module pxv_layout_xform
   import pxv_pkg::*;
#(
   parameter int CVEC   = 16,
   parameter int COMP_W = 8
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic                   in_valid,
   output logic                   in_ready,
   input  logic [COMP_W-1:0]      in_red,
   input  logic [COMP_W-1:0]      in_green,
   input  logic [COMP_W-1:0]      in_blue,
   input  logic                   in_sof,
   input  logic                   in_eol,
   output logic                   out_valid,
   input  logic                   out_ready,
   output logic [CVEC*HALF_W-1:0] out_vec,
   output logic                   out_sof,
   output logic                   out_eol
);
   localparam int COMPS_W = NUM_COLOR * COMP_W;
   localparam int S1_W    = COMPS_W + 2;
   localparam int VEC_W   = CVEC * HALF_W;
   localparam int S2_W    = VEC_W + 2;

   if (CVEC < NUM_COLOR) begin : g_bad_cvec
      $error("pxv_layout_xform: CVEC must hold at least three lanes");
   end
   if (COMP_W < 1 || COMP_W > FRAC_W + 1) begin : g_bad_comp
      $error("pxv_layout_xform: COMP_W must be 1..11 for exact FP16");
   end

   logic              s1_valid;
   logic              s1_ready;
   logic [S1_W-1:0]   s1_data;
   logic [S2_W-1:0]   s2_data;
   logic [VEC_W-1:0]  packed_vec;
   logic [COMPS_W-1:0] comps_in;

   assign comps_in = {in_blue, in_green, in_red};

   // Stage 1: raw pixel and markers.
   pxv_pipe_reg #(.W(S1_W)) u_stage_pix (
      .clk      (clk),
      .rst      (rst),
      .up_valid (in_valid),
      .up_ready (in_ready),
      .up_data  ({in_sof, in_eol, comps_in}),
      .dn_valid (s1_valid),
      .dn_ready (s1_ready),
      .dn_data  (s1_data)
   );

   // Conversion and lane placement between the two registers.
   pxv_lane_pack #(.CVEC(CVEC), .COMP_W(COMP_W)) u_pack (
      .comps (s1_data[COMPS_W-1:0]),
      .vec   (packed_vec)
   );

   // Stage 2: finished vector and markers.
   pxv_pipe_reg #(.W(S2_W)) u_stage_vec (
      .clk      (clk),
      .rst      (rst),
      .up_valid (s1_valid),
      .up_ready (s1_ready),
      .up_data  ({s1_data[S1_W-1], s1_data[S1_W-2], packed_vec}),
      .dn_valid (out_valid),
      .dn_ready (out_ready),
      .dn_data  (s2_data)
   );

   assign out_vec = s2_data[VEC_W-1:0];
   assign out_eol = s2_data[VEC_W];
   assign out_sof = s2_data[VEC_W+1];
endmodule

// File: rtl/pxv_layout_xform_chk.sv
module pxv_layout_xform_chk
   import pxv_pkg::*;
#(
   parameter int CVEC   = 16,
   parameter int COMP_W = 8
) (
   input logic                   clk,
   input logic                   rst,
   input logic                   in_ready,
   input logic                   out_valid,
   input logic                   out_ready,
   input logic [CVEC*HALF_W-1:0] out_vec,
   input logic                   out_sof,
   input logic                   out_eol,
   input logic                   s1_valid
);
   function automatic logic half_ok(input logic [HALF_W-1:0] h);
      half_ok = (h == '0) ||
                (!h[HALF_W-1] &&
                 h[HALF_W-2:FRAC_W] >= EXP_W'(EXP_BIAS) &&
                 h[HALF_W-2:FRAC_W] <= EXP_W'(EXP_BIAS + COMP_W - 1));
   endfunction

   AST_RESET_IDLE: assert property (@(posedge clk) rst |=> !out_valid); // R1

   AST_RED_FORM: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> half_ok(out_vec[LANE_RED*HALF_W +: HALF_W])); // R3
   AST_GRN_FORM: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> half_ok(out_vec[LANE_GRN*HALF_W +: HALF_W])); // R3
   AST_BLU_FORM: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> half_ok(out_vec[LANE_BLU*HALF_W +: HALF_W])); // R3

   if (CVEC > NUM_COLOR) begin : g_pad_chk
      AST_PAD_ZERO: assert property (@(posedge clk) disable iff (rst)
         out_valid |-> out_vec[CVEC*HALF_W-1:NUM_COLOR*HALF_W] == '0); // R4
   end

   AST_ADVANCE: assert property (@(posedge clk) disable iff (rst)
      s1_valid && (!out_valid || out_ready) |=> out_valid); // R6

   AST_HOLD: assert property (@(posedge clk) disable iff (rst)
      out_valid && !out_ready |=>
         out_valid && $stable(out_vec) && $stable(out_sof) && $stable(out_eol)); // R7

   AST_FULL_BLOCK: assert property (@(posedge clk) disable iff (rst)
      s1_valid && out_valid && !out_ready |-> !in_ready); // R8
endmodule

bind pxv_layout_xform pxv_layout_xform_chk #(.CVEC(CVEC), .COMP_W(COMP_W)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .in_ready  (in_ready),
   .out_valid (out_valid),
   .out_ready (out_ready),
   .out_vec   (out_vec),
   .out_sof   (out_sof),
   .out_eol   (out_eol),
   .s1_valid  (s1_valid)
);

// File: tb/pxv_layout_xform_test.sv
module pxv_layout_xform_test;
   localparam int CLK_PERIOD = 10;
   localparam int HALF       = CLK_PERIOD / 2;
   localparam int CVEC       = 16;
   localparam int CW         = 8;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic in_valid = 1'b0;
   logic in_ready;
   logic [CW-1:0] in_red = '0, in_green = '0, in_blue = '0;
   logic in_sof = 1'b0, in_eol = 1'b0;
   logic out_valid;
   logic out_ready = 1'b0;
   logic [CVEC*16-1:0] out_vec;
   logic out_sof, out_eol;

   int checks = 0;
   int errors = 0;
   int acc_count = 0;
   int out_count = 0;
   int rdy_mode = 1;     // 0 stalled, 1 always ready, 2 irregular
   int rdy_tick = 0;
   bit done = 1'b0;
   logic [3*CW+1:0] expq [$];

   always #(HALF) clk = ~clk;

   pxv_layout_xform #(.CVEC(CVEC), .COMP_W(CW)) uut (
      .clk(clk), .rst(rst),
      .in_valid(in_valid), .in_ready(in_ready),
      .in_red(in_red), .in_green(in_green), .in_blue(in_blue),
      .in_sof(in_sof), .in_eol(in_eol),
      .out_valid(out_valid), .out_ready(out_ready),
      .out_vec(out_vec), .out_sof(out_sof), .out_eol(out_eol)
   );

   // Reference conversion by repeated doubling, independent of the RTL.
   function automatic logic [15:0] ref_half(input int v);
      int m;
      int e;
      if (v == 0) return 16'h0000;
      m = v;
      e = 25;
      while (m < 1024) begin
         m = m * 2;
         e = e - 1;
      end
      return {1'b0, e[4:0], m[9:0]};
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   always @(negedge clk) begin
      rdy_tick++;
      case (rdy_mode)
         0: out_ready <= 1'b0;
         1: out_ready <= 1'b1;
         default: out_ready <= ((rdy_tick % 3) != 0) && ((rdy_tick % 7) != 2);
      endcase
   end

   // Output monitor and scoreboard.
   always begin
      @(negedge clk);
      #(HALF - 1);
      if (!rst && out_valid && out_ready) begin
         if (expq.size() == 0) begin
            check(1'b0, "R5", "vector with no accepted pixel", 64'(out_count), 64'(acc_count));
         end else begin
            logic [3*CW+1:0] e;
            logic [15:0] r_h, g_h, b_h;
            e = expq.pop_front();
            r_h = ref_half(int'(e[CW-1:0]));
            g_h = ref_half(int'(e[2*CW-1:CW]));
            b_h = ref_half(int'(e[3*CW-1:2*CW]));
            check(out_vec[15:0] == r_h, "R2 R3", "red lane 0", 64'(out_vec[15:0]), 64'(r_h));
            check(out_vec[31:16] == g_h, "R2 R3", "green lane 1", 64'(out_vec[31:16]), 64'(g_h));
            check(out_vec[47:32] == b_h, "R2 R3", "blue lane 2", 64'(out_vec[47:32]), 64'(b_h));
            check(out_vec[CVEC*16-1:48] == '0, "R4", "padding lanes", 64'(out_vec[CVEC*16-1:48]), 64'h0);
            check({out_sof, out_eol} == e[3*CW+1:3*CW], "R9", "sof/eol markers",
                  64'({out_sof, out_eol}), 64'(e[3*CW+1:3*CW]));
         end
         out_count++;
      end
   end

   task automatic offer(input logic [CW-1:0] r, g, b, input logic s, e,
                        input int max_cyc, output bit acc);
      acc = 1'b0;
      @(negedge clk);
      in_valid = 1'b1;
      in_red = r; in_green = g; in_blue = b;
      in_sof = s; in_eol = e;
      for (int c = 0; c < max_cyc && !acc; c++) begin
         if (c > 0) @(negedge clk);
         #(HALF - 1);
         if (in_ready) begin
            acc = 1'b1;
            expq.push_back({s, e, b, g, r});
            acc_count++;
         end
         @(posedge clk);
      end
   endtask

   task automatic idle(input int n);
      @(negedge clk);
      in_valid = 1'b0;
      repeat (n) @(posedge clk);
   endtask

   task automatic t_reset();
      rst = 1'b1;
      in_valid = 1'b1;
      repeat (3) begin
         @(negedge clk);
         #(HALF - 1);
         check(out_valid == 1'b0, "R1", "out_valid during reset", 64'(out_valid), 64'h0);
      end
      @(negedge clk);
      in_valid = 1'b0;
      rst = 1'b0;
      repeat (2) begin
         @(negedge clk);
         #(HALF - 1);
         check(out_valid == 1'b0, "R1", "out_valid idle after reset", 64'(out_valid), 64'h0);
         check(in_ready == 1'b1, "R1", "in_ready after reset", 64'(in_ready), 64'h1);
      end
   endtask

   task automatic t_latency();
      bit acc;
      rdy_mode = 1;
      idle(3);
      offer(8'd1, 8'd2, 8'd4, 1'b1, 1'b0, 4, acc);
      check(acc, "R6", "pixel accepted into empty pipe", 64'(acc), 64'h1);
      @(negedge clk);
      in_valid = 1'b0;
      #(HALF - 1);
      check(out_valid == 1'b0, "R6", "not visible after first edge", 64'(out_valid), 64'h0);
      @(negedge clk);
      #(HALF - 1);
      check(out_valid == 1'b1, "R6", "visible after second edge", 64'(out_valid), 64'h1);
      idle(3);
   endtask

   task automatic t_directed();
      bit acc;
      rdy_mode = 1;
      offer(8'd0, 8'd0, 8'd0, 1'b0, 1'b0, 4, acc);
      offer(8'd255, 8'd128, 8'd7, 1'b0, 1'b1, 4, acc);
      offer(8'd3, 8'd64, 8'd200, 1'b1, 1'b1, 4, acc);
      idle(4);
   endtask

   task automatic t_stall();
      bit acc;
      int got;
      logic [CVEC*16-1:0] held;
      logic [1:0] held_flags;
      rdy_mode = 1;
      idle(3);
      rdy_mode = 0;
      idle(2);
      got = 0;
      offer(8'd10, 8'd20, 8'd30, 1'b1, 1'b0, 4, acc);
      if (acc) got++;
      offer(8'd40, 8'd50, 8'd60, 1'b0, 1'b1, 4, acc);
      if (acc) got++;
      offer(8'd70, 8'd80, 8'd90, 1'b0, 1'b0, 4, acc);
      if (acc) got++;
      check(got == 2, "R8", "pixels accepted while stalled", 64'(got), 64'd2);
      check(in_ready == 1'b0, "R8", "in_ready with full pipe", 64'(in_ready), 64'h0);
      @(negedge clk);
      in_valid = 1'b0;
      #(HALF - 1);
      held = out_vec;
      held_flags = {out_sof, out_eol};
      repeat (4) begin
         @(negedge clk);
         #(HALF - 1);
         check(out_valid == 1'b1, "R7", "valid held in stall", 64'(out_valid), 64'h1);
         check(out_vec == held && {out_sof, out_eol} == held_flags, "R7", "vector held in stall",
               64'(out_vec[63:0]), 64'(held[63:0]));
      end
      rdy_mode = 1;
      idle(5);
   endtask

   task automatic t_sweep();
      bit acc;
      rdy_mode = 2;
      for (int i = 0; i < 256; i++) begin
         offer(CW'(i), CW'(255 - i), CW'((i * 37) % 256), i == 0, (i % 16) == 15, 40, acc);
         if (!acc) check(1'b0, "R5", "sweep pixel not accepted", 64'(i), 64'h1);
      end
      rdy_mode = 1;
      idle(6);
      check(expq.size() == 0, "R5", "pending pixels after drain", 64'(expq.size()), 64'h0);
      check(out_count == acc_count, "R5", "vectors vs accepted pixels",
            64'(out_count), 64'(acc_count));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_latency();
      t_directed();
      t_stall();
      t_sweep();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule